// File: doc/BRIEF.md
# Redundant SAR Conversion Sequencer

This block sequences one successive-approximation ADC channel whose capacitive DAC has non-binary weights (each capacitor 1.85 times the one below it, plus a spare unit capacitor that is not switched). While the active-low start input is low the channel samples, and nothing is tested. Once start is released, the block tests one capacitor per SAR clock period. It goes from the largest capacitor down to the smallest and raises the comparator strobe for each step. Each decision is captured into a per-bit cell that holds it for the rest of the conversion.

Each resolved capacitor has its top plate tied either to the positive or to the negative reference. A direct/reverse select inverts the meaning of the comparator output. After the last step the block runs a one-cycle plate reset phase that returns every capacitor to common mode, and pulses a done flag with the raw decision word. Pulling start low at any time aborts the conversion and clears all captured decisions.

Top module: `sar_ctrl`

## Requirements
- R1: While rst_ni is low and in the first cycle after it, strobe_o, done_o, rst_plate_o, sw_p_o, sw_n_o and word_o are all zero, and the block waits idle for a start.
- R2: In any cycle that follows a rising clock edge where start_ni was low, strobe_o, rst_plate_o, done_o and all switch controls are low.
- R3: After an edge where start_ni is high following a sampling cycle, strobe_o is high for exactly NBITS (default 11) consecutive cycles, one decision per cycle.
- R4: The decision captured at each strobed edge is cmp_i XOR rev_i (rev_i = 1 selects reverse switching). Step k (k = 0 first) stores it in word_o[NBITS-1-k], so bit NBITS-1 belongs to the largest capacitor.
- R5: During a strobed cycle the capacitor under test has sw_p_o = 1 and sw_n_o = 0. Each already-resolved capacitor has sw_p_o equal to its stored decision and sw_n_o equal to its complement. Unresolved capacitors have both controls low.
- R6: For no capacitor are sw_p_o and sw_n_o high at the same time, and both are low in every non-strobed cycle.
- R7: In the cycle after the last decision is captured, done_o and rst_plate_o are both high, for that one cycle only.
- R8: After the conversion, word_o keeps the decision word unchanged for as long as start_ni stays high.
- R9: start_ni low during a conversion aborts it: from the next cycle the strobe is low and word_o reads zero.
- R10: After the plate reset phase, with start_ni high, the block stays idle with no strobe and no switch activity until start_ni goes low again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | SAR clock (half the master rate) |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_ni | input | 1 | Active-low sample/start, low while sampling |
| cmp_i | input | 1 | Comparator decision |
| rev_i | input | 1 | 1 selects reverse switching polarity |
| strobe_o | output | 1 | Comparator strobe enable, high per bit test |
| sw_p_o | output | NBITS | Top plate to positive reference, per capacitor |
| sw_n_o | output | NBITS | Top plate to negative reference, per capacitor |
| rst_plate_o | output | 1 | Plate reset phase control |
| word_o | output | NBITS | Raw decision word, MSB = largest capacitor |
| done_o | output | 1 | One-cycle conversion complete flag |

## Verification
The checker assumes that cmp_i and rev_i are stable around each rising clock edge. It also assumes that start_ni changes only between edges, as a synchronized sampling clock would. The bench drives every input on the falling edge, so each value is settled a half period before the edge that uses it. rev_i is changed only while the channel samples. The bench still exercises aborts at arbitrary steps and start pulses a single cycle long, which the properties have to tolerate.

// File: rtl/sar_pkg.sv
package sar_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SAMP = 2'd1,
    ST_CONV = 2'd2,
    ST_PRST = 2'd3
  } sar_state_e;
endpackage

// File: rtl/sar_seq.sv
module sar_seq
  import sar_pkg::*;
#(
  parameter int NBITS = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_ni,
  output sar_state_e       state_o,
  output logic [NBITS-1:0] sel_o,
  output logic             done_o
);
  localparam logic [NBITS-1:0] MSB_HOT = {1'b1, {(NBITS-1){1'b0}}};

  sar_state_e       state_q;
  logic [NBITS-1:0] sel_q;
  logic             done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      sel_q   <= '0;
      done_q  <= 1'b0;
    end else if (!start_ni) begin
      state_q <= ST_SAMP;
      sel_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: state_q <= ST_IDLE;
        ST_SAMP: begin
          state_q <= ST_CONV;
          sel_q   <= MSB_HOT;
        end
        ST_CONV: begin
          sel_q <= sel_q >> 1;
          if (sel_q[0]) begin
            state_q <= ST_PRST;
            done_q  <= 1'b1;
          end
        end
        ST_PRST: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign state_o = state_q;
  assign sel_o   = sel_q;
  assign done_o  = done_q;
endmodule

// File: rtl/sar_bit_cell.sv
module sar_bit_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic cap_i,
  input  logic d_i,
  output logic dec_o,
  output logic res_o
);
  logic dec_q, res_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dec_q <= 1'b0;
      res_q <= 1'b0;
    end else if (clr_i) begin
      dec_q <= 1'b0;
      res_q <= 1'b0;
    end else if (cap_i) begin
      dec_q <= d_i;
      res_q <= 1'b1;
    end
  end

  assign dec_o = dec_q;
  assign res_o = res_q;
endmodule

// File: rtl/sar_sw_drv.sv
module sar_sw_drv #(
  parameter int NBITS = 11
) (
  input  logic             conv_i,
  input  logic [NBITS-1:0] sel_i,
  input  logic [NBITS-1:0] dec_i,
  input  logic [NBITS-1:0] res_i,
  output logic [NBITS-1:0] sw_p_o,
  output logic [NBITS-1:0] sw_n_o
);
  for (genvar i = 0; i < NBITS; i++) begin : g_drv
    // trial level on the bit under test, latched level on resolved bits
    assign sw_p_o[i] = conv_i & (res_i[i] ? dec_i[i] : sel_i[i]);
    assign sw_n_o[i] = conv_i & res_i[i] & ~dec_i[i];
  end
endmodule

// File: rtl/sar_ctrl.sv
module sar_ctrl
  import sar_pkg::*;
#(
  parameter int NBITS = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_ni,
  input  logic             cmp_i,
  input  logic             rev_i,
  output logic             strobe_o,
  output logic [NBITS-1:0] sw_p_o,
  output logic [NBITS-1:0] sw_n_o,
  output logic             rst_plate_o,
  output logic [NBITS-1:0] word_o,
  output logic             done_o
);
  sar_state_e       state;
  logic [NBITS-1:0] sel, dec, res;
  logic             conv, dbit;

  sar_seq #(.NBITS(NBITS)) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_ni(start_ni),
    .state_o (state),
    .sel_o   (sel),
    .done_o  (done_o)
  );

  assign conv = (state == ST_CONV);
  assign dbit = cmp_i ^ rev_i;

  for (genvar i = 0; i < NBITS; i++) begin : g_bit
    sar_bit_cell u_cell (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .clr_i (~start_ni),
      .cap_i (conv & sel[i]),
      .d_i   (dbit),
      .dec_o (dec[i]),
      .res_o (res[i])
    );
  end

  sar_sw_drv #(.NBITS(NBITS)) u_drv (
    .conv_i(conv),
    .sel_i (sel),
    .dec_i (dec),
    .res_i (res),
    .sw_p_o(sw_p_o),
    .sw_n_o(sw_n_o)
  );

  assign strobe_o    = conv;
  assign rst_plate_o = (state == ST_PRST);
  assign word_o      = dec;
endmodule

// File: rtl/sar_ctrl_chk.sv
module sar_ctrl_chk #(
  parameter int NBITS = 11
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_ni,
  input logic             cmp_i,
  input logic             rev_i,
  input logic             strobe_o,
  input logic [NBITS-1:0] sw_p_o,
  input logic [NBITS-1:0] sw_n_o,
  input logic             rst_plate_o,
  input logic [NBITS-1:0] word_o,
  input logic             done_o
);
  assert_no_short_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sw_p_o & sw_n_o) == '0);

  assert_sw_idle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !strobe_o |-> (sw_p_o == '0 && sw_n_o == '0));

  assert_sample_quiet_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_ni |=> (!strobe_o && !rst_plate_o && !done_o));

  assert_abort_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_ni |=> word_o == '0);

  assert_done_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_done_reset_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (rst_plate_o && !strobe_o));

  assert_word_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && start_ni) |=> $stable(word_o));

  assert_trial_one_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_o |-> $countones(sw_p_o | sw_n_o) >= 1);
endmodule

bind sar_ctrl sar_ctrl_chk #(.NBITS(NBITS)) u_chk (.*);

// File: tb/sar_ctrl_tb.sv
module sar_ctrl_tb_top;
  localparam int N = 11;
  localparam time CLK_PERIOD = 10ns;

  logic clk_i = 1'b0, rst_ni = 1'b0, start_ni = 1'b1, cmp_i = 1'b0, rev_i = 1'b0;
  logic strobe_o, rst_plate_o, done_o;
  logic [N-1:0] sw_p_o, sw_n_o, word_o;

  sar_ctrl #(.NBITS(N)) dut_i (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  // behavioural model: 0 idle, 1 sampling, 2 converting, 3 plate reset
  int m_state, m_step;
  logic [N-1:0] m_word;
  bit m_done;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_state = 0; m_step = 0; m_word = '0; m_done = 0;
    end else if (!start_ni) begin
      m_state = 1; m_step = 0; m_word = '0; m_done = 0;
    end else begin
      m_done = 0;
      if (m_state == 1) begin
        m_state = 2; m_step = N - 1;
      end else if (m_state == 2) begin
        m_word[m_step] = cmp_i ^ rev_i;
        if (m_step == 0) begin m_state = 3; m_done = 1; end
        else m_step = m_step - 1;
      end else if (m_state == 3) m_state = 0;
    end
  end

  task automatic chk(string tag, logic [N-1:0] act, logic [N-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // compare every cycle, half a period after the edge
  always @(negedge clk_i) begin
    if (rst_ni && !finished) begin
      logic [N-1:0] ep, en;
      ep = '0; en = '0;
      if (m_state == 2)
        for (int i = 0; i < N; i++) begin
          if (i > m_step) begin ep[i] = m_word[i]; en[i] = ~m_word[i]; end
          else if (i == m_step) ep[i] = 1'b1;
        end
      chk(m_state == 0 ? "R10" : (m_state == 1 ? "R2" : "R3"),
          N'(strobe_o), N'(m_state == 2));
      chk("R7 plate", N'(rst_plate_o), N'(m_state == 3));
      chk("R7 done", N'(done_o), N'(m_done));
      chk("R5 sw_p", sw_p_o, ep);
      chk("R5 sw_n", sw_n_o, en);
      chk("R6", sw_p_o & sw_n_o, '0);
      chk(m_state == 1 ? "R9" : (m_state == 0 ? "R8" : "R4"), word_o, m_word);
    end
  end

  // one conversion; abort_at < 0 means no abort
  task automatic convert(logic [N-1:0] pat, logic rev, int abort_at, int samp_len);
    @(negedge clk_i);
    start_ni = 1'b0; rev_i = rev;
    repeat (samp_len - 1) @(negedge clk_i);
    @(negedge clk_i);
    start_ni = 1'b1;
    for (int c = 0; c < N + 4; c++) begin
      @(negedge clk_i);
      cmp_i = pat[m_step];
      if (c == abort_at) start_ni = 1'b0;
    end
    @(negedge clk_i);
    start_ni = 1'b1;
    repeat (3) @(negedge clk_i);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    // R1: reset values
    chk("R1 outs", {N'(strobe_o | done_o | rst_plate_o)}, '0);
    chk("R1 word", word_o | sw_p_o | sw_n_o, '0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 idle", N'(strobe_o), '0);
    convert(11'h5A3, 1'b0, -1, 2);   // R4 direct
    convert(11'h5A3, 1'b1, -1, 1);   // R4 reverse
    convert(11'h7FF, 1'b0, -1, 3);
    convert(11'h000, 1'b0, -1, 1);
    convert(11'h2D4, 1'b0, 4, 2);    // R9 abort mid conversion
    convert(11'h155, 1'b1, 0, 1);    // R9 abort on first step
    convert(11'h3C7, 1'b0, N - 1, 2); // abort on last test
    for (int r = 0; r < 6; r++) convert(N'($urandom), 1'($urandom), -1, 1 + r % 3);
    repeat (5) @(negedge clk_i);     // R10 idle after reset phase
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk_i);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule